// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns two digitised supply-monitor flags into the core reset of a chip. One flag reports that the supply is above a high rising threshold. The other reports that the supply is above a much lower falling threshold. A free-running timebase clocks the block. When power comes up, the block keeps the core in reset until the high flag is seen. It then counts a fixed number of timebase cycles and releases reset only at the end of that count. The delay is a parameter in clock cycles, so a simulation can use a short delay while silicon uses one of about 128 ms.

Assert and release are deliberately asymmetric. Once the core has been released, a sag below the high threshold is ignored. Reset comes back only when the low flag drops. It comes back asynchronously, with no clock needed. The next power-up then repeats the whole wait-and-count sequence. If the high flag drops while the delay is counting, the count is abandoned and the block waits for the flag again. Both flags are brought into the clock domain through a two-flop synchroniser. The low flag also acts as the asynchronous clear of every register in the block. A status output shows that the delay counter is running.

Top module: `por_seq`

## Requirements
- R1: While `lo_ok_i` is 0, `core_rst_o` is 1 and `delay_busy_o` is 0. A fall of `lo_ok_i` raises `core_rst_o` without waiting for a clock edge.
- R2: While `lo_ok_i` is 1 and `hi_ok_i` stays 0, `core_rst_o` stays 1 for any length of time.
- R3: Take `lo_ok_i` at 1 since at least the edge before, and `hi_ok_i` rising between two clock edges and then held at 1. `core_rst_o` falls on the (DELAY_CYCLES+3)-th rising edge after `hi_ok_i` rose: two edges of synchroniser, one edge to start counting, and DELAY_CYCLES edges of count.
- R4: `delay_busy_o` is 1 for exactly the DELAY_CYCLES clock cycles that come right before the release of `core_rst_o`. It is 0 at all other times, and it is never 1 while `core_rst_o` is 0.
- R5: If `hi_ok_i` drops after d edges (counted from its rise), with d at most DELAY_CYCLES, the count is abandoned. `core_rst_o` stays 1 and `delay_busy_o` returns to 0. When `hi_ok_i` rises again, the full R3 delay applies.
- R6: Once `core_rst_o` is 0, changes of `hi_ok_i` have no effect. `core_rst_o` stays 0 as long as `lo_ok_i` stays 1.
- R7: After `lo_ok_i` falls and rises again, the complete sequence of R2 and R3 repeats from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timebase clock |
| lo_ok_i | input | 1 | Supply above the low falling threshold; 0 clears the block asynchronously |
| hi_ok_i | input | 1 | Supply above the high rising threshold |
| core_rst_o | output | 1 | Active-high core reset |
| delay_busy_o | output | 1 | Release delay counter is running |

## Verification
The assertions rely on three properties of the inputs:
- Every low phase of `lo_ok_i` spans at least one rising clock edge, so a glitch that comes and goes between two edges is never seen.
- `hi_ok_i` is never 1 while `lo_ok_i` is 0.
- Both flags change only between clock edges.

The stimulus follows all three. It moves the flags on falling clock edges and holds every power-down for several cycles. It raises `hi_ok_i` only after `lo_ok_i` is high. It then sweeps the point at which `hi_ok_i` drops across every edge of the delay window and just past it.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    PS_HOLD  = 2'd0,
    PS_COUNT = 2'd1,
    PS_RUN   = 2'd2
  } por_state_e;
endpackage

// File: rtl/por_sync.sv
// Multi-stage flag synchroniser, cleared asynchronously.
module por_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/por_timer.sv
// Release delay counter: clears while idle, flags its final cycle.
module por_timer #(
  parameter int DELAY_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST_VAL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = run_i && (cnt_q == LAST_VAL);
endmodule

// File: rtl/por_ctrl.sv
// Sequencing state machine with a dedicated reset output flop.
module por_ctrl
  import por_pkg::*;
(
  input  logic clk_i,
  input  logic clr_ni,
  input  logic lo_s_i,
  input  logic hi_s_i,
  input  logic last_i,
  output logic run_o,
  output logic rst_o
);
  por_state_e state_q, state_d;
  logic       rst_q, rst_d;

  always_comb begin
    state_d = state_q;
    rst_d   = rst_q;
    unique case (state_q)
      PS_HOLD: begin
        rst_d = 1'b1;
        if (lo_s_i && hi_s_i) state_d = PS_COUNT;
      end
      PS_COUNT: begin
        if (!lo_s_i || !hi_s_i) begin
          state_d = PS_HOLD;
        end else if (last_i) begin
          state_d = PS_RUN;
          rst_d   = 1'b0;
        end
      end
      PS_RUN: begin
        if (!lo_s_i) begin
          state_d = PS_HOLD;
          rst_d   = 1'b1;
        end
      end
      default: begin
        state_d = PS_HOLD;
        rst_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      state_q <= PS_HOLD;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  assign run_o = (state_q == PS_COUNT);
  assign rst_o = rst_q;
endmodule

// File: rtl/por_seq.sv
// Top: synchronise supply flags, sequence the core reset.
module por_seq #(
  parameter int DELAY_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic lo_ok_i,
  input  logic hi_ok_i,
  output logic core_rst_o,
  output logic delay_busy_o
);
  logic [1:0] flags_s;
  logic       run;
  logic       last;

  por_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .clr_ni (lo_ok_i),
    .d_i    ({hi_ok_i, 1'b1}),
    .q_o    (flags_s)
  );

  por_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .clr_ni (lo_ok_i),
    .run_i  (run),
    .last_o (last)
  );

  por_ctrl u_ctrl (
    .clk_i  (clk_i),
    .clr_ni (lo_ok_i),
    .lo_s_i (flags_s[0]),
    .hi_s_i (flags_s[1]),
    .last_i (last),
    .run_o  (run),
    .rst_o  (core_rst_o)
  );

  assign delay_busy_o = run;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
  parameter int DELAY_CYCLES = 4096
) (
  input logic clk_i,
  input logic lo_ok_i,
  input logic hi_ok_i,
  input logic core_rst_o,
  input logic delay_busy_o
);
  localparam int BW = $clog2(DELAY_CYCLES + 2) + 1;
  logic [BW-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge lo_ok_i) begin
    if (!lo_ok_i) begin
      busy_run_q <= '0;
    end else if (delay_busy_o) begin
      busy_run_q <= busy_run_q + 1'b1;
    end else begin
      busy_run_q <= '0;
    end
  end

  a_r1_rst_while_low: assert property (@(posedge clk_i)
    !lo_ok_i |-> (core_rst_o && !delay_busy_o));

  a_r4_busy_implies_rst: assert property (@(posedge clk_i) disable iff (!lo_ok_i)
    delay_busy_o |-> core_rst_o);

  a_r4_busy_bounded: assert property (@(posedge clk_i) disable iff (!lo_ok_i)
    busy_run_q <= BW'(DELAY_CYCLES));

  a_r3_release_after_count: assert property (@(posedge clk_i) disable iff (!lo_ok_i)
    $fell(core_rst_o) |-> ($past(delay_busy_o) && busy_run_q == BW'(DELAY_CYCLES)));

  a_r6_stays_released: assert property (@(posedge clk_i) disable iff (!lo_ok_i)
    !core_rst_o |=> !core_rst_o);

  a_r6_hi_ignored: assert property (@(posedge clk_i) disable iff (!lo_ok_i)
    (!core_rst_o && !hi_ok_i) |=> !delay_busy_o);
endmodule

bind por_seq por_seq_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .lo_ok_i      (lo_ok_i),
  .hi_ok_i      (hi_ok_i),
  .core_rst_o   (core_rst_o),
  .delay_busy_o (delay_busy_o)
);

// File: tb/sim_por_seq.sv
module sim_por_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 6;
  localparam int REL = DLY + 3;

  logic clk = 1'b0;
  logic lo_ok = 1'b1;
  logic hi_ok = 1'b0;
  logic core_rst;
  logic busy;

  int checks = 0;
  int errors = 0;

  por_seq #(.DELAY_CYCLES(DLY), .SYNC_STAGES(2)) u0 (
    .clk_i        (clk),
    .lo_ok_i      (lo_ok),
    .hi_ok_i      (hi_ok),
    .core_rst_o   (core_rst),
    .delay_busy_o (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic power_down();
    @(negedge clk);
    hi_ok = 1'b0;
    #1 lo_ok = 1'b0;
    #1 chk(core_rst === 1'b1, "R1 async assert", int'(core_rst), 1);
    cycles(4);
    chk(core_rst === 1'b1 && busy === 1'b0, "R1 held while low", int'({core_rst, busy}), 2);
    @(negedge clk);
    lo_ok = 1'b1;
  endtask

  // Raise hi at a negedge and measure edges to release plus busy cycles.
  task automatic measure_release(input string req);
    int edges;
    int busy_cnt;
    edges = 0;
    busy_cnt = 0;
    hi_ok = 1'b1;
    while (core_rst === 1'b1 && edges < REL + 10) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (busy === 1'b1) busy_cnt++;
    end
    chk(edges == REL, {req, " release edge"}, edges, REL);
    chk(busy_cnt == DLY, "R4 busy length", busy_cnt, DLY);
    chk(busy === 1'b0, "R4 busy low after release", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2 lo_ok = 1'b0;
    #1 chk(core_rst === 1'b1, "R1 reset state", int'(core_rst), 1);
    cycles(3);
    chk(busy === 1'b0, "R1 busy low in reset", int'(busy), 0);
    lo_ok = 1'b1;

    // R2: hi held low for a long time
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      chk(core_rst === 1'b1 && busy === 1'b0, "R2 hold without hi", int'({core_rst, busy}), 2);
    end

    // R3/R4: first release
    measure_release("R3");

    // R6: hi toggling after release
    for (int i = 0; i < 12; i++) begin
      hi_ok = (i % 3 != 0);
      @(negedge clk);
      chk(core_rst === 1'b0 && busy === 1'b0, "R6 hi ignored", int'({core_rst, busy}), 0);
    end
    hi_ok = 1'b1;

    // R5 sweep: drop hi after d edges, for d = 1 .. DLY+3
    for (int d = 1; d <= DLY + 3; d++) begin
      power_down();
      cycles(2);
      hi_ok = 1'b1;
      cycles(d);
      hi_ok = 1'b0;
      cycles(REL + 4);
      if (d >= DLY + 1) begin
        chk(core_rst === 1'b0, "R5 late drop releases", int'(core_rst), 0);
      end else begin
        chk(core_rst === 1'b1, "R5 abort holds reset", int'(core_rst), 1);
        chk(busy === 1'b0, "R5 abort clears busy", int'(busy), 0);
        measure_release("R5 restart");
      end
    end

    // R7: repeated power cycles with simultaneous rise of both flags
    for (int k = 0; k < 3; k++) begin
      power_down();
      cycles(k);
      measure_release("R7");
    end

    // R7: lo and hi rising together at one negedge
    power_down();
    cycles(3);
    lo_ok = 1'b0;
    cycles(2);
    lo_ok = 1'b1;
    measure_release("R7 joint rise");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule